// File: doc/BRIEF.md
# Bus-Attached Serial Modem Controller

This block is a slave on a parallel processor bus and joins that bus to one asynchronous serial line. The host sees three registers: a control register, a status register and a data register. When the host writes a byte to the data register, the block sends it on the line as a serial frame. The block also assembles incoming serial frames into bytes. The host collects each byte by reading the data register. The bit period is the bus clock divided by a parameter-derived ratio (`CLK_HZ / BAUD_HZ`), which is 1200 baud at the defaults.

A transfer-pending status bit tells the host when data is ready to move. It is set when a frame finishes going out and when a valid byte arrives. It is cleared by any access to the data register. When the control enable bit is set, the block raises an interrupt request from the pending bit. When the enable bit is clear, the host polls the status register instead. Each decoded access is answered with a one-clock active-low done pulse.

Three state machines make up the block:
- **Bus machine.** Its states are BUS_IDLE, BUS_ACK and BUS_WAIT. In BUS_IDLE, a strobe to a mapped address leads to BUS_ACK, and a strobe to an unmapped address leads to BUS_WAIT. BUS_ACK returns to BUS_IDLE if the strobes are released, and otherwise goes to BUS_WAIT. BUS_WAIT returns to BUS_IDLE once both strobes are high.
- **Transmitter.** Its states are TX_IDLE, TX_START, TX_DATA and TX_STOP. A load moves it from TX_IDLE to TX_START. Each bit tick then moves it on: TX_START to TX_DATA, TX_DATA to TX_STOP after the eighth bit, and TX_STOP back to TX_IDLE.
- **Receiver.** Its states are RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_BREAK. A low line moves it from RX_IDLE to RX_START. At the half-bit tick, RX_START goes to RX_DATA if the line is still low, and back to RX_IDLE if it is high. RX_DATA goes to RX_STOP after the eighth sample. At the stop sample, RX_STOP goes to RX_IDLE if the line is high, and to RX_BREAK if it is low. RX_BREAK returns to RX_IDLE when the line goes high.

Top module: `sermod_ctl`

## Requirements
- R1: After reset, `bus_done_n` and `ser_tx` are 1, `irq` is 0, and both the control and status registers read as 0.
- R2: A strobe (`bus_wr_n` or `bus_rd_n` low) to address 0, 1 or 2 gives `bus_done_n` low for exactly one clock, in the cycle after the strobe is first seen. A strobe to address 3 never gives done.
- R3: The address map is as follows. Address 0 is control, with bit 0 as the interrupt enable; it reads back as {7'b0, enable}. Address 1 is status, with bit 0 as pending and bit 1 as transmitter busy. Address 2 is data. Read data is valid on `bus_rdata` while done is low.
- R4: A write to address 2 while the transmitter is idle sends a frame. The frame is a start bit of 0, then eight data bits with the LSB first, then a stop bit of 1. Each bit lasts `CLK_HZ/BAUD_HZ` clocks. The start bit begins in the cycle in which done is low.
- R5: A write to address 2 while a frame is being sent is ignored: the frame in progress is unchanged and no second frame follows.
- R6: The receiver samples the line at the middle of each bit, LSB first. A frame with a stop bit of 1 stores its byte, and the byte is returned by a read of address 2.
- R7: A frame whose stop sample is 0 is discarded. Pending is not set, and the data register keeps the previous byte. The receiver waits for the line to go high before it looks for a new start bit.
- R8: Pending is set at the end of each transmitted frame and on each valid received byte. It is cleared by a read or write of address 2, and is unaffected by control or status accesses. If a set and a clear happen in the same cycle, the set wins.
- R9: `irq` equals pending AND the enable bit. With the enable bit at 0, `irq` stays low while the status register still shows pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data from the host |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_rdata | output | 8 | Read data to the host |
| bus_done_n | output | 1 | Active-low access-complete pulse |
| ser_tx | output | 1 | Serial output line, idle high |
| ser_rx | input | 1 | Serial input line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a data-register access that lands in the same clock as the end of an outgoing frame. This is the only way to show that a pending set beats a pending clear. The bench writes a byte and counts exactly ten bit periods, less one cycle, before it drives a read strobe. It then checks that `irq` stays high with the interrupt enabled. A receive frame with a low stop bit held for a full period is also sent, to drive the receiver through its break-wait state.

// File: rtl/sermod_pkg.sv
package sermod_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ACK,
        BUS_WAIT
    } bus_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;

endpackage

// File: rtl/sermod_baud.sv
// Bit-period tick source: first tick FIRST cycles after clr, then every DIV.
module sermod_baud #(
    parameter int unsigned DIV   = 10,
    parameter int unsigned FIRST = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= CW'(FIRST - 1);
        end else if (cnt == '0) begin
            cnt <= CW'(DIV - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/sermod_tx.sv
module sermod_tx
    import sermod_pkg::*;
#(
    parameter int unsigned DIV = 10,
    parameter int unsigned DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic          ser_out,
    output logic          busy,
    output logic          done
);
    localparam int unsigned IW = $clog2(DW);

    tx_state_e     state, nxt;
    logic [DW-1:0] sh;
    logic [IW-1:0] bit_idx;
    logic          tick;

    sermod_baud #(.DIV(DIV), .FIRST(DIV)) i_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == TX_IDLE),
        .tick (tick)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (load) nxt = TX_START;
            TX_START: if (tick) nxt = TX_DATA;
            TX_DATA:  if (tick && bit_idx == IW'(DW - 1)) nxt = TX_STOP;
            TX_STOP:  if (tick) nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            sh      <= '0;
            bit_idx <= '0;
        end else begin
            state <= nxt;
            if (state == TX_IDLE && load) begin
                sh      <= din;
                bit_idx <= '0;
            end else if (state == TX_DATA && tick) begin
                sh      <= sh >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        ser_out = 1'b1;
        unique case (state)
            TX_IDLE:  ser_out = 1'b1;
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = sh[0];
            TX_STOP:  ser_out = 1'b1;
        endcase
        busy = (state != TX_IDLE);
        done = (state == TX_STOP) && tick;
    end

    // R4: a load from idle drives the start bit on the next cycle
    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && load) |=> !ser_out);

    // R4: the frame-end pulse lasts one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a load during a frame does not restart it
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA && load && !tick) |=> $stable(sh));

endmodule

// File: rtl/sermod_rx.sv
module sermod_rx
    import sermod_pkg::*;
#(
    parameter int unsigned DIV = 10,
    parameter int unsigned DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    output logic [DW-1:0] dout,
    output logic          done
);
    localparam int unsigned IW   = $clog2(DW);
    localparam int unsigned HALF = (DIV / 2 > 0) ? DIV / 2 : 1;

    rx_state_e     state, nxt;
    logic          s1, s2;
    logic [DW-1:0] sh;
    logic [IW-1:0] bit_idx;
    logic          tick;

    sermod_baud #(.DIV(DIV), .FIRST(HALF)) i_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == RX_IDLE),
        .tick (tick)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (!s2) nxt = RX_START;
            RX_START: if (tick) nxt = s2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && bit_idx == IW'(DW - 1)) nxt = RX_STOP;
            RX_STOP:  if (tick) nxt = s2 ? RX_IDLE : RX_BREAK;
            RX_BREAK: if (s2) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            state   <= RX_IDLE;
            sh      <= '0;
            bit_idx <= '0;
            dout    <= '0;
        end else begin
            s1    <= ser_in;
            s2    <= s1;
            state <= nxt;
            if (state == RX_START) begin
                bit_idx <= '0;
            end else if (state == RX_DATA && tick) begin
                sh      <= {s2, sh[DW-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
            if (done) begin
                dout <= sh;
            end
        end
    end

    always_comb begin
        done = (state == RX_STOP) && tick && s2;
    end

    // R7: a low stop sample leaves the stored byte untouched
    p_bad_stop_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && tick && !s2) |=> $stable(dout));

    // R7: no new start is accepted while waiting out a break
    p_break_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_BREAK && !s2) |=> state == RX_BREAK);

endmodule

// File: rtl/sermod_ctl.sv
module sermod_ctl
    import sermod_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned BAUD_HZ = 1200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr_n,
    input  logic       bus_rd_n,
    output logic [7:0] bus_rdata,
    output logic       bus_done_n,
    output logic       ser_tx,
    input  logic       ser_rx,
    output logic       irq
);
    localparam int unsigned DW  = 8;
    localparam int unsigned DIV = CLK_HZ / BAUD_HZ;

    bus_state_e    state, nxt;
    logic          strobe, mapped, acc, wr_acc, rd_acc, data_acc;
    logic          ctrl_en, pend;
    logic          tx_busy, tx_done, rx_done;
    logic [DW-1:0] rx_byte;

    assign strobe   = !bus_wr_n || !bus_rd_n;
    assign mapped   = (bus_addr == ADR_CTRL) || (bus_addr == ADR_STAT) ||
                      (bus_addr == ADR_DATA);
    assign acc      = (state == BUS_IDLE) && strobe && mapped;
    assign wr_acc   = acc && !bus_wr_n;
    assign rd_acc   = acc && bus_wr_n;
    assign data_acc = acc && (bus_addr == ADR_DATA);

    sermod_tx #(.DIV(DIV), .DW(DW)) i_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_acc && bus_addr == ADR_DATA),
        .din    (bus_wdata),
        .ser_out(ser_tx),
        .busy   (tx_busy),
        .done   (tx_done)
    );

    sermod_rx #(.DIV(DIV), .DW(DW)) i_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .ser_in(ser_rx),
        .dout  (rx_byte),
        .done  (rx_done)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            BUS_IDLE: if (strobe) nxt = mapped ? BUS_ACK : BUS_WAIT;
            BUS_ACK:  nxt = strobe ? BUS_WAIT : BUS_IDLE;
            BUS_WAIT: if (!strobe) nxt = BUS_IDLE;
            default:  nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= BUS_IDLE;
            ctrl_en   <= 1'b0;
            pend      <= 1'b0;
            bus_rdata <= '0;
        end else begin
            state <= nxt;
            if (wr_acc && bus_addr == ADR_CTRL) begin
                ctrl_en <= bus_wdata[0];
            end
            if (tx_done || rx_done) begin
                pend <= 1'b1;
            end else if (data_acc) begin
                pend <= 1'b0;
            end
            if (rd_acc) begin
                unique case (bus_addr)
                    ADR_CTRL: bus_rdata <= {7'b0, ctrl_en};
                    ADR_STAT: bus_rdata <= {6'b0, tx_busy, pend};
                    default:  bus_rdata <= rx_byte;
                endcase
            end
        end
    end

    always_comb begin
        bus_done_n = (state != BUS_ACK);
        irq        = pend && ctrl_en;
    end

    // R2: done is a single-cycle pulse
    p_done_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_done_n |=> bus_done_n);

    // R2: an unmapped address never completes
    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_IDLE && strobe && bus_addr == 2'd3) |=> bus_done_n);

    // R8: frame events always leave pending set (set beats clear)
    p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done || rx_done) |=> pend);

    // R8: status and control accesses keep pending
    p_pend_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_addr != ADR_DATA && pend) |=> pend);

    // R9: with the enable set, a frame event raises the request
    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !(wr_acc && bus_addr == ADR_CTRL) && (tx_done || rx_done)) |=> irq);

endmodule

// File: tb/test_sermod_ctl.sv
module test_sermod_ctl;
    localparam int unsigned DIV = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_wr_n;
    logic       bus_rd_n;
    logic [7:0] bus_rdata;
    logic       bus_done_n;
    logic       ser_tx;
    logic       ser_rx;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sermod_ctl #(.CLK_HZ(12000), .BAUD_HZ(1200)) i_sermod_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr_n  (bus_wr_n),
        .bus_rd_n  (bus_rd_n),
        .bus_rdata (bus_rdata),
        .bus_done_n(bus_done_n),
        .ser_tx    (ser_tx),
        .ser_rx    (ser_rx),
        .irq       (irq)
    );

    task automatic chk(input logic [9:0] act, input logic [9:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] frame_of(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    function automatic logic [7:0] stat_of(input logic busy, input logic pend);
        return {6'b0, busy, pend};
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_n = 1'b0;
        @(negedge clk);
        chk(10'(bus_done_n), 10'd0, "R2 write done");
        bus_wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_n = 1'b0;
        @(negedge clk);
        chk(10'(bus_done_n), 10'd0, "R2 read done");
        d = bus_rdata;
        bus_rd_n = 1'b1;
    endtask

    task automatic capture_tx(input int skip, output logic [9:0] bits);
        repeat (DIV / 2 - skip) @(negedge clk);
        bits[0] = ser_tx;
        for (int k = 1; k < 10; k++) begin
            repeat (DIV) @(negedge clk);
            bits[k] = ser_tx;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        logic [9:0] f;
        f = {stop, b, 1'b0};
        for (int k = 0; k < 10; k++) begin
            ser_rx = f[k];
            repeat (DIV) @(negedge clk);
        end
        ser_rx = 1'b1;
        repeat (DIV) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd, b, last_rx;
        logic [9:0] fr;
        b = 8'($urandom(32'd1234));
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0;
        bus_wr_n = 1'b1; bus_rd_n = 1'b1; ser_rx = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(10'(bus_done_n), 10'd1, "R1 done idle");
        chk(10'(ser_tx), 10'd1, "R1 line idle");
        chk(10'(irq), 10'd0, "R1 irq low");
        bus_read(2'd0, rd); chk(10'(rd), 10'd0, "R1 control");
        bus_read(2'd1, rd); chk(10'(rd), 10'd0, "R1 status");

        // R3 control read-back
        bus_write(2'd0, 8'hA5); bus_read(2'd0, rd); chk(10'(rd), 10'h01, "R3 enable set");
        bus_write(2'd0, 8'hFE); bus_read(2'd0, rd); chk(10'(rd), 10'h00, "R3 enable clear");

        // R2 unmapped address: no done
        @(negedge clk);
        bus_addr = 2'd3; bus_wr_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(10'(bus_done_n), 10'd1, "R2 unmapped no done");
        end
        bus_wr_n = 1'b1;

        // R4 random transmit frames, R8 pending after each
        for (int i = 0; i < 4; i++) begin
            b = 8'($urandom);
            bus_write(2'd2, b);
            capture_tx(0, fr);
            chk(fr, frame_of(b), "R4 tx frame");
            repeat (DIV) @(negedge clk);
            bus_read(2'd1, rd);
            chk(10'(rd), 10'(stat_of(1'b0, 1'b1)), "R8 pend after tx");
        end
        bus_read(2'd1, rd);
        chk(10'(rd), 10'(stat_of(1'b0, 1'b1)), "R8 status read keeps pend");

        // R5 write during frame ignored
        bus_write(2'd2, 8'h3C);
        bus_read(2'd1, rd);
        chk(10'(rd), 10'(stat_of(1'b1, 1'b0)), "R8 write clears pend, busy");
        bus_write(2'd2, 8'hC3);
        capture_tx(4, fr);
        chk(fr, frame_of(8'h3C), "R5 frame unchanged");
        repeat (3 * DIV) @(negedge clk);
        chk(10'(ser_tx), 10'd1, "R5 no second frame");
        bus_read(2'd1, rd);
        chk(10'(rd), 10'(stat_of(1'b0, 1'b1)), "R5 idle after one frame");

        // R9 enable with pend set; R8 set wins over coincident clear
        bus_write(2'd0, 8'h01);
        chk(10'(irq), 10'd1, "R9 irq follows enable");
        bus_write(2'd2, 8'h81);
        chk(10'(irq), 10'd0, "R9 irq drops on clear");
        repeat (10 * DIV - 1) @(negedge clk);
        bus_addr = 2'd2; bus_rd_n = 1'b0;
        @(negedge clk);
        chk(10'(bus_done_n), 10'd0, "R2 coincident read done");
        chk(10'(irq), 10'd1, "R8 set wins");
        bus_rd_n = 1'b1;
        bus_read(2'd2, rd);
        chk(10'(irq), 10'd0, "R8 data read clears");

        // R6 random receive with interrupt enabled
        for (int i = 0; i < 4; i++) begin
            b = 8'($urandom);
            send_rx(b, 1'b1);
            chk(10'(irq), 10'd1, "R9 irq on rx");
            bus_read(2'd1, rd);
            chk(10'(rd), 10'(stat_of(1'b0, 1'b1)), "R6 pend on rx");
            bus_read(2'd2, rd);
            chk(10'(rd), 10'(b), "R6 rx byte");
            last_rx = b;
        end
        send_rx(8'h00, 1'b1);
        bus_read(2'd2, rd); chk(10'(rd), 10'h00, "R6 rx zero byte");
        send_rx(8'hFF, 1'b1);
        bus_read(2'd2, rd); chk(10'(rd), 10'hFF, "R6 rx ones byte");
        last_rx = 8'hFF;

        // R9 polling mode
        bus_write(2'd0, 8'h00);
        send_rx(8'h5A, 1'b1);
        chk(10'(irq), 10'd0, "R9 irq masked");
        bus_read(2'd1, rd);
        chk(10'(rd), 10'(stat_of(1'b0, 1'b1)), "R9 polled pend");
        bus_read(2'd2, rd); chk(10'(rd), 10'h5A, "R6 polled byte");
        last_rx = 8'h5A;

        // R7 bad stop discarded, then recovery
        send_rx(8'h96, 1'b0);
        bus_read(2'd1, rd);
        chk(10'(rd), 10'(stat_of(1'b0, 1'b0)), "R7 no pend on bad stop");
        bus_read(2'd2, rd);
        chk(10'(rd), 10'(last_rx), "R7 byte kept");
        send_rx(8'h69, 1'b1);
        bus_read(2'd2, rd);
        chk(10'(rd), 10'h69, "R7 recovery byte");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule